// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central controller for a machine that runs instructions out of order across five functional units: two multipliers, one divider, one adder and one integer unit. The integer unit also handles memory and branch operations. The datapath and the units stay outside. The controller decides three things for each instruction: when it may take a unit (issue), when that unit may read its source registers, and when the unit may put its result on the single result bus.

It keeps three tables. The first records, per unit, which instruction the unit holds and how far that instruction has gone. The second records which sources are still waiting on a producer. The third records, per architectural register, which unit will write it next. Issue is refused on a structural or write-after-write conflict. Operand read waits for read-after-write conflicts to clear. Write-back waits for write-after-read conflicts to clear. An instruction waiting on operands sits in its unit and does not block later, independent instructions. When resources allow, one instruction issues per clock.

Each unit works as a fixed-latency engine. It starts on the read pulse and, when it finishes, raises its completion input for one cycle.

Top module: `sb_ctrl`

## Requirements
- R1: During and straight after reset all units are free and no register has a pending writer. `in_ready` is high, and `rd_start`, `wb_grant` and `iss_oh` are all zero.
- R2: The class code on `in_cls` is 0 integer, 1 adder, 2 multiplier, 3 divider. Unit indices are 0 and 1 multiplier, 2 divider, 3 adder, 4 integer. An accepted instruction takes the lowest-index free unit of its class. Independent instructions for free units are accepted on consecutive cycles.
- R3: `in_ready` stays low while every unit of the requested class is busy. It rises in the cycle after the occupying unit's write-back grant. A unit is never allocated in the cycle it is granted.
- R4: `in_ready` stays low while any active instruction already targets `in_dst`. It rises in the cycle after that instruction's write-back grant.
- R5: A unit's `rd_start` is not raised while a source register has a pending producer. When the last producer is granted write-back in cycle g, `rd_start` rises in cycle g+1.
- R6: `rd_start` for a unit is a single-cycle pulse, raised once per instruction. The earliest cycle it can rise is the cycle after issue.
- R7: A completed unit is not granted write-back while an earlier-issued instruction that has not yet read its operands names the same register as a source. If that reader raises `rd_start` in cycle r, the grant can come in cycle r+1.
- R8: At most one bit of `wb_grant` is high in any cycle. A grant goes only to a unit whose completion has been accepted, and `wb_reg` then gives that unit's destination register.
- R9: Among units eligible for write-back, the one that has waited longest since completion wins. Equal waits go to the lower unit index.
- R10: A completion pulse on `fu_done` for an idle unit is ignored and never leads to a grant.
- R11: In a cycle where `in_valid` and `in_ready` are both high, `iss_oh` is the one-hot index of the unit being allocated. In every other cycle it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The offered instruction can issue this cycle |
| in_cls | input | 2 | Unit class of the instruction |
| in_dst | input | 4 | Destination register |
| in_src1 | input | 4 | First source register |
| in_src2 | input | 4 | Second source register |
| iss_oh | output | 5 | One-hot unit allocated this cycle |
| rd_start | output | 5 | Per unit: read operands and start now |
| fu_done | input | 5 | Per unit: execution finished (one-cycle pulse) |
| wb_grant | output | 5 | Per unit: write the result this cycle |
| wb_reg | output | 4 | Register written under the current grant |

## Verification
A corrupted writer-table entry appears at `in_ready` as a missed or spurious WAW stall on the next instruction that names that register. A stale pending-source flag delays or advances `rd_start` by at least one cycle against the producer's grant. A wrong read-done or completion bit shows as a write-back that comes early, late or on the wrong unit. The bench measures the cycle distances between grants, read starts and issue acceptance, so any of these errors shows within one cycle of the event that should have released the instruction. A wrong destination field or arbitration age shows on `wb_reg` and on the order of grants, both compared against an expected queue at every grant.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int N_MUL  = 2;
    localparam int N_DIV  = 1;
    localparam int N_ADD  = 1;
    localparam int N_INT  = 1;
    localparam int N_UNIT = N_MUL + N_DIV + N_ADD + N_INT;
    localparam int UW     = (N_UNIT > 1) ? $clog2(N_UNIT) : 1;
    localparam int N_REG  = 16;
    localparam int RW     = $clog2(N_REG);
    localparam int AGE_W  = 4;
    localparam int AGE_MAX = (1 << AGE_W) - 1;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_ADD = 2'd1,
        CLS_MUL = 2'd2,
        CLS_DIV = 2'd3
    } cls_e;

    typedef struct packed {
        logic          busy;
        logic          rd_done;
        logic          ex_done;
        logic [RW-1:0] dst;
        logic [RW-1:0] s1;
        logic [RW-1:0] s2;
        logic          p1;
        logic          p2;
        logic [UW-1:0] q1;
        logic [UW-1:0] q2;
    } slot_t;

    typedef struct packed {
        logic          v;
        logic [UW-1:0] u;
    } wr_t;

    typedef struct packed {
        slot_t [N_UNIT-1:0]             slot;
        logic  [N_UNIT-1:0][AGE_W-1:0]  age;
        wr_t   [N_REG-1:0]              wr;
    } state_t;

    function automatic cls_e unit_cls(input int u);
        if (u < N_MUL)                      return CLS_MUL;
        else if (u < N_MUL + N_DIV)         return CLS_DIV;
        else if (u < N_MUL + N_DIV + N_ADD) return CLS_ADD;
        else                                return CLS_INT;
    endfunction
endpackage

// File: rtl/sb_alloc.sv
module sb_alloc
    import sb_pkg::*;
(
    input  logic [N_UNIT-1:0] busy,
    input  cls_e              cls,
    output logic              found,
    output logic [UW-1:0]     idx
);
    logic [N_UNIT-1:0] cand;

    for (genvar u = 0; u < N_UNIT; u++) begin : g_cand
        assign cand[u] = !busy[u] && (unit_cls(u) == cls);
    end

    // descending scan: the lowest matching index is the last one kept
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int u = N_UNIT - 1; u >= 0; u--) begin
            if (cand[u]) begin
                found = 1'b1;
                idx   = UW'(u);
            end
        end
    end
endmodule

// File: rtl/sb_hazard.sv
module sb_hazard
    import sb_pkg::*;
(
    input  slot_t [N_UNIT-1:0] slot,
    output logic  [N_UNIT-1:0] rd_go,
    output logic  [N_UNIT-1:0] wb_req
);
    for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
        logic [N_UNIT-1:0] blk;

        for (genvar v = 0; v < N_UNIT; v++) begin : g_peer
            if (v == u) begin : g_self
                assign blk[v] = 1'b0;
            end else begin : g_other
                // v still needs the old value of u's destination when the
                // matching source does not point at u as its producer
                logic hit1;
                logic hit2;
                assign hit1 = (slot[v].s1 == slot[u].dst)
                              && !(slot[v].p1 && (slot[v].q1 == UW'(u)));
                assign hit2 = (slot[v].s2 == slot[u].dst)
                              && !(slot[v].p2 && (slot[v].q2 == UW'(u)));
                assign blk[v] = slot[v].busy && !slot[v].rd_done && (hit1 || hit2);
            end
        end

        assign rd_go[u]  = slot[u].busy && !slot[u].rd_done && !slot[u].p1 && !slot[u].p2;
        assign wb_req[u] = slot[u].busy && slot[u].ex_done && !(|blk);
    end
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb
    import sb_pkg::*;
(
    input  logic [N_UNIT-1:0]            req,
    input  logic [N_UNIT-1:0][AGE_W-1:0] age,
    output logic                         gnt_v,
    output logic [UW-1:0]                gnt_idx,
    output logic [N_UNIT-1:0]            gnt
);
    logic [AGE_W-1:0] best;

    // ascending scan with strict compare: ties stay with the lower index
    always_comb begin
        gnt_v   = 1'b0;
        gnt_idx = '0;
        best    = '0;
        for (int u = 0; u < N_UNIT; u++) begin
            if (req[u] && (!gnt_v || (age[u] > best))) begin
                gnt_v   = 1'b1;
                gnt_idx = UW'(u);
                best    = age[u];
            end
        end
        gnt = gnt_v ? (N_UNIT'(1) << gnt_idx) : '0;
    end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_cls,
    input  logic [RW-1:0]     in_dst,
    input  logic [RW-1:0]     in_src1,
    input  logic [RW-1:0]     in_src2,
    output logic [N_UNIT-1:0] iss_oh,
    output logic [N_UNIT-1:0] rd_start,
    input  logic [N_UNIT-1:0] fu_done,
    output logic [N_UNIT-1:0] wb_grant,
    output logic [RW-1:0]     wb_reg
);
    state_t st_q, st_d;

    logic [N_UNIT-1:0] busy_v;
    logic [N_UNIT-1:0] wb_req;
    logic              a_found;
    logic [UW-1:0]     a_idx;
    logic              gnt_v;
    logic [UW-1:0]     gnt_idx;
    logic              take;
    wr_t               w1, w2;

    for (genvar u = 0; u < N_UNIT; u++) begin : g_busy
        assign busy_v[u] = st_q.slot[u].busy;
    end

    sb_alloc u_alloc (
        .busy  (busy_v),
        .cls   (cls_e'(in_cls)),
        .found (a_found),
        .idx   (a_idx)
    );

    sb_hazard u_hazard (
        .slot   (st_q.slot),
        .rd_go  (rd_start),
        .wb_req (wb_req)
    );

    sb_wb_arb u_arb (
        .req     (wb_req),
        .age     (st_q.age),
        .gnt_v   (gnt_v),
        .gnt_idx (gnt_idx),
        .gnt     (wb_grant)
    );

    assign in_ready = a_found && !st_q.wr[in_dst].v;
    assign take     = in_valid && in_ready;
    assign iss_oh   = take ? (N_UNIT'(1) << a_idx) : '0;
    assign wb_reg   = gnt_v ? st_q.slot[gnt_idx].dst : '0;
    assign w1       = st_q.wr[in_src1];
    assign w2       = st_q.wr[in_src2];

    always_comb begin
        st_d = st_q;

        for (int u = 0; u < N_UNIT; u++) begin
            if (rd_start[u]) begin
                st_d.slot[u].rd_done = 1'b1;
            end
            if (st_q.slot[u].ex_done && (st_q.age[u] != AGE_W'(AGE_MAX))) begin
                st_d.age[u] = st_q.age[u] + 1'b1;
            end
            if (fu_done[u] && st_q.slot[u].busy && st_q.slot[u].rd_done
                && !st_q.slot[u].ex_done) begin
                st_d.slot[u].ex_done = 1'b1;
                st_d.age[u]          = '0;
            end
            // result broadcast releases every source waiting on the winner
            if (gnt_v && st_q.slot[u].p1 && (st_q.slot[u].q1 == gnt_idx)) begin
                st_d.slot[u].p1 = 1'b0;
            end
            if (gnt_v && st_q.slot[u].p2 && (st_q.slot[u].q2 == gnt_idx)) begin
                st_d.slot[u].p2 = 1'b0;
            end
        end

        if (gnt_v) begin
            st_d.slot[gnt_idx].busy    = 1'b0;
            st_d.slot[gnt_idx].rd_done = 1'b0;
            st_d.slot[gnt_idx].ex_done = 1'b0;
            st_d.slot[gnt_idx].p1      = 1'b0;
            st_d.slot[gnt_idx].p2      = 1'b0;
            st_d.age[gnt_idx]          = '0;
            if (st_q.wr[st_q.slot[gnt_idx].dst].u == gnt_idx) begin
                st_d.wr[st_q.slot[gnt_idx].dst].v = 1'b0;
            end
        end

        if (take) begin
            st_d.slot[a_idx].busy    = 1'b1;
            st_d.slot[a_idx].rd_done = 1'b0;
            st_d.slot[a_idx].ex_done = 1'b0;
            st_d.slot[a_idx].dst     = in_dst;
            st_d.slot[a_idx].s1      = in_src1;
            st_d.slot[a_idx].s2      = in_src2;
            st_d.slot[a_idx].p1      = w1.v && !(gnt_v && (gnt_idx == w1.u));
            st_d.slot[a_idx].p2      = w2.v && !(gnt_v && (gnt_idx == w2.u));
            st_d.slot[a_idx].q1      = w1.u;
            st_d.slot[a_idx].q2      = w2.u;
            st_d.age[a_idx]          = '0;
            st_d.wr[in_dst].v        = 1'b1;
            st_d.wr[in_dst].u        = a_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sb_ctrl_chk.sv
module sb_ctrl_chk
    import sb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [N_UNIT-1:0] iss_oh,
    input logic [N_UNIT-1:0] rd_start,
    input logic [N_UNIT-1:0] wb_grant
);
    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_grant));

    p_grant_no_repeat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|wb_grant) |=> ((wb_grant & $past(wb_grant)) == '0));

    p_alloc_not_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((iss_oh & wb_grant) == '0));

    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_start) |=> ((rd_start & $past(rd_start)) == '0));

    p_no_start_at_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((iss_oh & rd_start) == '0));

    p_iss_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> $onehot(iss_oh));

    p_iss_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |-> (iss_oh == '0));
endmodule

bind sb_ctrl sb_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .iss_oh   (iss_oh),
    .rd_start (rd_start),
    .wb_grant (wb_grant)
);

// File: tb/sb_ctrl_tb.sv
module sb_ctrl_tb;
    import sb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic              clk;
    logic              rst_n;
    logic              in_valid;
    logic              in_ready;
    logic [1:0]        in_cls;
    logic [RW-1:0]     in_dst, in_src1, in_src2;
    logic [N_UNIT-1:0] iss_oh, rd_start, fu_done, wb_grant;
    logic [RW-1:0]     wb_reg;
    logic [N_UNIT-1:0] model_done, man_done;
    bit                manual;

    typedef struct { int unit; int rg; } exp_t;
    exp_t q[$];

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int cnt[N_UNIT];
    int start_cyc[N_UNIT];
    int grant_cyc[N_UNIT];

    sb_ctrl u_dut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready), .in_cls (in_cls),
        .in_dst (in_dst), .in_src1 (in_src1), .in_src2 (in_src2),
        .iss_oh (iss_oh), .rd_start (rd_start), .fu_done (fu_done),
        .wb_grant (wb_grant), .wb_reg (wb_reg)
    );

    assign fu_done = manual ? man_done : model_done;

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= WD_LIMIT) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int lat_of(input int u);
        case (unit_cls(u))
            CLS_MUL: return 10;
            CLS_DIV: return 40;
            CLS_ADD: return 2;
            default: return 0;
        endcase
    endfunction

    // fixed-latency unit model
    always @(negedge clk) begin
        for (int u = 0; u < N_UNIT; u++) begin
            model_done[u] = 1'b0;
            if (!rst_n) begin
                cnt[u] = 0;
            end else if (rd_start[u]) begin
                cnt[u] = lat_of(u) + 1;
            end else if (cnt[u] > 0) begin
                cnt[u] = cnt[u] - 1;
                if (cnt[u] == 0) model_done[u] = 1'b1;
            end
        end
    end

    // monitor: compare every grant with the expected queue
    always @(negedge clk) begin
        if (rst_n) begin
            for (int u = 0; u < N_UNIT; u++) begin
                if (rd_start[u]) start_cyc[u] = cyc;
            end
            if (wb_grant != '0) begin
                int gi;
                gi = -1;
                for (int u = 0; u < N_UNIT; u++) begin
                    if (wb_grant[u]) gi = u;
                end
                grant_cyc[gi] = cyc;
                if (q.size() == 0) begin
                    chk("R8/R10", "unexpected grant unit", gi, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R9/R8", "grant unit", gi, e.unit);
                    chk("R8", "wb_reg", int'(wb_reg), e.rg);
                end
            end
        end
    end

    task automatic send(input cls_e c, input int d, input int s1, input int s2,
                        output int icyc, output int oh);
        in_cls   = c;
        in_dst   = RW'(d);
        in_src1  = RW'(s1);
        in_src2  = RW'(s2);
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        icyc = cyc;
        oh   = int'(iss_oh);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_wb(input int u, input int r);
        exp_t e;
        e.unit = u;
        e.rg   = r;
        q.push_back(e);
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int c1, c2, c3, oh;
        rst_n = 1'b0; in_valid = 1'b0; in_cls = '0;
        in_dst = '0; in_src1 = '0; in_src2 = '0;
        manual = 1'b0; man_done = '0;
        for (int u = 0; u < N_UNIT; u++) begin
            start_cyc[u] = 0;
            grant_cyc[u] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "in_ready after reset", int'(in_ready), 1);
        chk("R1", "rd_start after reset", int'(rd_start), 0);
        chk("R1", "wb_grant after reset", int'(wb_grant), 0);
        chk("R1", "iss_oh after reset", int'(iss_oh), 0);
        @(negedge clk);

        // single add: unit 3, read the cycle after issue
        expect_wb(3, 1);
        send(CLS_ADD, 1, 2, 3, c1, oh);
        chk("R11", "add allocation one-hot", oh, 8);
        drain();
        chk("R6", "add read cycle after issue", start_cyc[3], c1 + 1);

        // structural: second divide waits for the only divider
        expect_wb(2, 4);
        expect_wb(2, 5);
        send(CLS_DIV, 4, 0, 0, c1, oh);
        chk("R2", "divide to unit 2", oh, 4);
        send(CLS_DIV, 5, 0, 0, c2, oh);
        chk("R3", "second divide accepted cycle after grant", c2, grant_cyc[2] + 1);
        drain();

        // two multipliers, then a RAW consumer on the first
        expect_wb(0, 6);
        expect_wb(1, 14);
        expect_wb(3, 7);
        send(CLS_MUL, 6, 2, 3, c1, oh);
        chk("R2", "first multiply to unit 0", oh, 1);
        send(CLS_MUL, 14, 2, 3, c2, oh);
        chk("R2", "second multiply to unit 1", oh, 2);
        send(CLS_ADD, 7, 6, 6, c3, oh);
        drain();
        chk("R5", "consumer read cycle after producer grant", start_cyc[3], grant_cyc[0] + 1);

        // WAW: integer op on a register a multiply still owns
        expect_wb(0, 8);
        expect_wb(4, 8);
        send(CLS_MUL, 8, 1, 1, c1, oh);
        send(CLS_INT, 8, 1, 1, c2, oh);
        chk("R4", "WAW stall until cycle after grant", c2, grant_cyc[0] + 1);
        drain();

        // WAR: fast integer write waits for an older pending reader
        expect_wb(2, 12);
        expect_wb(4, 13);
        expect_wb(3, 11);
        send(CLS_DIV, 12, 0, 0, c1, oh);
        send(CLS_ADD, 11, 12, 13, c2, oh);
        send(CLS_INT, 13, 0, 0, c3, oh);
        drain();
        chk("R5", "reader starts after divide grant", start_cyc[3], grant_cyc[2] + 1);
        chk("R7", "integer grant cycle after reader start", grant_cyc[4], start_cyc[3] + 1);

        // completion on an idle unit must not produce a grant
        manual = 1'b1;
        @(negedge clk);
        man_done = 5'b00010;
        @(negedge clk);
        man_done = '0;
        repeat (5) begin
            @(negedge clk);
            #1;
            chk("R10", "no grant after idle completion", int'(wb_grant), 0);
        end

        // back-to-back issue and longest-wait arbitration
        expect_wb(3, 2);
        expect_wb(4, 1);
        expect_wb(0, 3);
        send(CLS_INT, 1, 0, 0, c1, oh);
        chk("R2", "integer to unit 4", oh, 16);
        send(CLS_ADD, 2, 0, 0, c2, oh);
        chk("R2", "add accepted next cycle", c2, c1 + 1);
        send(CLS_MUL, 3, 0, 0, c3, oh);
        chk("R2", "multiply accepted next cycle", c3, c2 + 1);
        repeat (3) @(negedge clk);
        man_done = 5'b11000;
        @(negedge clk);
        man_done = 5'b00001;
        @(negedge clk);
        man_done = '0;
        drain();
        chk("R9", "older unit 4 beats new unit 0", grant_cyc[4], grant_cyc[3] + 1);
        chk("R9", "unit 0 granted last", grant_cyc[0], grant_cyc[4] + 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule